// File: doc/BRIEF.md
# Upstream High-Speed Detection Handshake

This block is the upstream-port controller that reacts to a single-ended-zero (SE0) condition on the link towards the host. It decides whether that SE0 is a bus reset. When it is, it runs the chirp negotiation that either brings the hub up at high speed or leaves it at full speed. It sees the decoded upstream line state, a suspended flag and a periodic time-base strobe (one strobe per microsecond in the default configuration). It drives three outputs: a command to send chirp K upstream, the high-speed enable, and a one-cycle pulse when a reset handshake starts.

The block chooses how long to wait on SE0 from the mode it is in. A suspended full-speed hub starts almost at once. An awake full-speed hub waits a longer window. A high-speed hub first drops back to full speed. After a settle interval it samples the line: SE0 still present means a reset, anything else means suspend. Once the handshake starts, the block drives chirp K for a fixed time. It then listens for an alternating, filtered chirp sequence from upstream within a deadline. If the deadline passes first, it falls back to full speed. Every interval is a parameter counted in time-base strobes, so that a bench can run with short times.

Top module: `hsnego_top`

## Requirements
- R1: After reset, driveChirpK, hsEnable and resetDetected are all low.
- R2: At full speed and not suspended, with lineState code 0 (SE0) held for FS_WAIT_TICKS strobes, resetDetected pulses and driveChirpK rises two clock cycles after the strobe that completes the count. If the line returns to code 1 (J) earlier, nothing starts.
- R3: At full speed with suspended high, the handshake starts in the same way after SUSP_TICKS strobes of SE0.
- R4: At high speed, hsEnable falls two cycles after the REVERT_TICKS-th strobe of continuous SE0. SAMPLE_TICKS strobes later the line is sampled. SE0 starts the handshake (resetDetected pulse and chirp K two cycles after that strobe). Any other state is taken as suspend, and no handshake starts.
- R5: driveChirpK stays high for CHIRP_TICKS strobes. It falls two cycles after the last of them, and hsEnable is never high while it is high.
- R6: An upstream chirp (lineState code 4 = chirp K, code 3 = chirp J) counts only once it has been held for FILT_TICKS strobes without a change of line state. A shorter chirp is ignored.
- R7: Counted chirps must alternate, starting with chirp K. A chirp of the wrong kind is ignored, and 2*CHIRP_PAIRS counted chirps complete the sequence.
- R8: hsEnable rises three clock cycles after the strobe that qualifies the final chirp J.
- R9: If the sequence is not complete within LISTEN_TICKS strobes after chirp K ends, the hub stays at full speed, and later chirps do not enable high speed.
- R10: After that fallback, SE0 that continues does not start a new handshake until the line has left SE0.
- R11: resetDetected is high for exactly one cycle per handshake start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | Time-base strobe, one cycle wide |
| lineState | input | 3 | Decoded upstream line: 0 SE0, 1 J, 2 K, 3 chirp J, 4 chirp K |
| suspended | input | 1 | Hub is in the suspended state |
| driveChirpK | output | 1 | Command to drive chirp K upstream |
| hsEnable | output | 1 | High-speed operation enabled |
| resetDetected | output | 1 | One-cycle pulse when a reset handshake starts |

## Verification
Each timed result has a fixed latency from the strobe that completes its count, because that strobe passes through a counter register and then the state register:
- The reset pulse, the rise of chirp K, the revert of hsEnable and the end of chirp K appear two cycles after that strobe.
- The high-speed enable appears three cycles after it, because the chirp qualifier adds a register.

The bench drives a strobe every fourth cycle and counts strobes itself. It checks each output one cycle before the due cycle and again in the due cycle. All samples are taken on the falling edge. The sweeps change the mode, the length of the SE0, the chirp order, the length of a chirp and where the deadline falls. The bench counts reset pulses on its own, so a missing or extra pulse is caught between the checks.

// File: rtl/hsnego_pkg.sv
package hsnego_pkg;

  // Decoded upstream line state codes
  typedef enum logic [2:0] {
    LS_SE0    = 3'd0,
    LS_J      = 3'd1,
    LS_K      = 3'd2,
    LS_CHIRPJ = 3'd3,
    LS_CHIRPK = 3'd4
  } lineCode_e;

  // Control to datapath strobes
  typedef struct packed {
    logic clrPhase;
    logic clrChirps;
    logic incChirp;
  } ctrlStrobe_t;

  // Datapath to control status
  typedef struct packed {
    logic lineSe0;
    logic seSuspHit;
    logic seFsHit;
    logic seRevertHit;
    logic phSampleHit;
    logic phChirpHit;
    logic phListenHit;
    logic chirpQual;
    logic qualIsK;
    logic expectK;
    logic chirpsDone;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REVERT = 3'd1,
    ST_CHIRP  = 3'd2,
    ST_LISTEN = 3'd3,
    ST_HOLD   = 3'd4
  } negState_e;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hsnego_satcnt.sv
// Saturating up-counter with synchronous clear (clear has priority).
module hsnego_satcnt #(
  parameter int W   = 8,
  parameter int MAX = 255
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(MAX);

  always_ff @(posedge clk) begin
    if (!rstN)                  cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != LIM) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/hsnego_dp.sv
// Timers, chirp filter and chirp counter.
module hsnego_dp
  import hsnego_pkg::*;
#(
  parameter int FILT_TICKS    = 3,
  parameter int SUSP_TICKS    = 3,
  parameter int FS_WAIT_TICKS = 1000,
  parameter int REVERT_TICKS  = 3050,
  parameter int SAMPLE_TICKS  = 200,
  parameter int CHIRP_TICKS   = 1500,
  parameter int LISTEN_TICKS  = 2000,
  parameter int CHIRP_PAIRS   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        usTick,
  input  logic [2:0]  lineState,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);
  localparam int SE_MAX  = maxOf(maxOf(SUSP_TICKS, FS_WAIT_TICKS), REVERT_TICKS);
  localparam int PH_MAX  = maxOf(maxOf(SAMPLE_TICKS, CHIRP_TICKS), LISTEN_TICKS);
  localparam int CNT_W   = $clog2(maxOf(SE_MAX, PH_MAX) + 1);
  localparam int RUN_W   = $clog2(FILT_TICKS + 1);
  localparam int CHIRP_N = 2 * CHIRP_PAIRS;
  localparam int CH_W    = $clog2(CHIRP_N + 1);
  localparam logic [RUN_W-1:0] FILT_LIM = RUN_W'(FILT_TICKS);

  logic             lineSe0;
  logic [CNT_W-1:0] seCnt;
  logic [CNT_W-1:0] phCnt;
  logic [CH_W-1:0]  chirpCnt;

  assign lineSe0 = (lineState == LS_SE0);

  // SE0 duration counter: restarts whenever the line leaves SE0
  hsnego_satcnt #(.W(CNT_W), .MAX(SE_MAX)) u_seCnt (
    .clk(clk), .rstN(rstN), .clr(!lineSe0), .inc(usTick), .cnt(seCnt)
  );

  // Phase counter for the timed states
  hsnego_satcnt #(.W(CNT_W), .MAX(PH_MAX)) u_phCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.clrPhase), .inc(usTick), .cnt(phCnt)
  );

  // Counted chirps
  hsnego_satcnt #(.W(CH_W), .MAX(CHIRP_N)) u_chirpCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.clrChirps), .inc(strobe.incChirp), .cnt(chirpCnt)
  );

  // Chirp filter: a run of one chirp kind must span FILT_TICKS strobes
  logic [2:0]       prevLine;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] nextRun;
  logic             isChirp;
  logic             sameRun;
  logic             hitNow;
  logic             qualReg;
  logic             qualKReg;

  assign isChirp = (lineState == LS_CHIRPJ) || (lineState == LS_CHIRPK);
  assign sameRun = (lineState == prevLine);

  always_comb begin
    nextRun = runCnt;
    if (!isChirp)                       nextRun = '0;
    else if (!sameRun)                  nextRun = usTick ? RUN_W'(1) : '0;
    else if (usTick && runCnt != FILT_LIM) nextRun = runCnt + RUN_W'(1);
  end

  assign hitNow = isChirp && (nextRun == FILT_LIM) && !(sameRun && runCnt == FILT_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLine <= LS_SE0;
      runCnt   <= '0;
      qualReg  <= 1'b0;
      qualKReg <= 1'b0;
    end else begin
      prevLine <= lineState;
      runCnt   <= nextRun;
      qualReg  <= hitNow;
      qualKReg <= (lineState == LS_CHIRPK);
    end
  end

  always_comb begin
    status.lineSe0     = lineSe0;
    status.seSuspHit   = (seCnt >= CNT_W'(SUSP_TICKS));
    status.seFsHit     = (seCnt >= CNT_W'(FS_WAIT_TICKS));
    status.seRevertHit = (seCnt >= CNT_W'(REVERT_TICKS));
    status.phSampleHit = (phCnt >= CNT_W'(SAMPLE_TICKS));
    status.phChirpHit  = (phCnt >= CNT_W'(CHIRP_TICKS));
    status.phListenHit = (phCnt >= CNT_W'(LISTEN_TICKS));
    status.chirpQual   = qualReg;
    status.qualIsK     = qualKReg;
    status.expectK     = !chirpCnt[0];
    status.chirpsDone  = (chirpCnt == CH_W'(CHIRP_N));
  end
endmodule

// File: rtl/hsnego_fsm.sv
// Handshake sequencing and mode register.
module hsnego_fsm
  import hsnego_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        suspended,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        driveChirpK,
  output logic        hsEnable,
  output logic        resetDetected
);
  negState_e state, nextState;
  logic hsMode;
  logic pulseReg;
  logic startHsk;
  logic revertNow;
  logic setHs;

  always_comb begin
    nextState = state;
    strobe    = '0;
    startHsk  = 1'b0;
    revertNow = 1'b0;
    setHs     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (status.lineSe0) begin
          if (hsMode) begin
            if (status.seRevertHit) begin
              nextState       = ST_REVERT;
              strobe.clrPhase = 1'b1;
              revertNow       = 1'b1;
            end
          end else if (suspended ? status.seSuspHit : status.seFsHit) begin
            nextState       = ST_CHIRP;
            strobe.clrPhase = 1'b1;
            startHsk        = 1'b1;
          end
        end
      end
      ST_REVERT: begin
        if (status.phSampleHit) begin
          if (status.lineSe0) begin
            nextState       = ST_CHIRP;
            strobe.clrPhase = 1'b1;
            startHsk        = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_CHIRP: begin
        if (status.phChirpHit) begin
          nextState        = ST_LISTEN;
          strobe.clrPhase  = 1'b1;
          strobe.clrChirps = 1'b1;
        end
      end
      ST_LISTEN: begin
        if (status.chirpsDone) begin
          nextState = ST_IDLE;
          setHs     = 1'b1;
        end else if (status.phListenHit) begin
          nextState = ST_HOLD;
        end else if (status.chirpQual && (status.qualIsK == status.expectK)) begin
          strobe.incChirp = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!status.lineSe0) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      hsMode   <= 1'b0;
      pulseReg <= 1'b0;
    end else begin
      state    <= nextState;
      pulseReg <= startHsk;
      if (setHs)          hsMode <= 1'b1;
      else if (revertNow) hsMode <= 1'b0;
    end
  end

  assign driveChirpK   = (state == ST_CHIRP);
  assign hsEnable      = hsMode;
  assign resetDetected = pulseReg;
endmodule

// File: rtl/hsnego_top.sv
module hsnego_top
  import hsnego_pkg::*;
#(
  parameter int FILT_TICKS    = 3,
  parameter int SUSP_TICKS    = 3,
  parameter int FS_WAIT_TICKS = 1000,
  parameter int REVERT_TICKS  = 3050,
  parameter int SAMPLE_TICKS  = 200,
  parameter int CHIRP_TICKS   = 1500,
  parameter int LISTEN_TICKS  = 2000,
  parameter int CHIRP_PAIRS   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic [2:0] lineState,
  input  logic       suspended,
  output logic       driveChirpK,
  output logic       hsEnable,
  output logic       resetDetected
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  hsnego_dp #(
    .FILT_TICKS(FILT_TICKS), .SUSP_TICKS(SUSP_TICKS), .FS_WAIT_TICKS(FS_WAIT_TICKS),
    .REVERT_TICKS(REVERT_TICKS), .SAMPLE_TICKS(SAMPLE_TICKS), .CHIRP_TICKS(CHIRP_TICKS),
    .LISTEN_TICKS(LISTEN_TICKS), .CHIRP_PAIRS(CHIRP_PAIRS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineState(lineState),
    .strobe(strobe), .status(status)
  );

  hsnego_fsm u_fsm (
    .clk(clk), .rstN(rstN), .suspended(suspended), .status(status), .strobe(strobe),
    .driveChirpK(driveChirpK), .hsEnable(hsEnable), .resetDetected(resetDetected)
  );
endmodule

// File: rtl/hsnego_checker.sv
module hsnego_checker
  import hsnego_pkg::*;
#(
  parameter int CHIRP_TICKS = 1500
) (
  input logic       clk,
  input logic       rstN,
  input logic       usTick,
  input logic [2:0] lineState,
  input logic       driveChirpK,
  input logic       hsEnable,
  input logic       resetDetected
);
  localparam int TW = $clog2(CHIRP_TICKS + 3);
  localparam logic [TW-1:0] TMAX = TW'(CHIRP_TICKS + 2);

  // Strobes seen while chirp K is driven
  logic [TW-1:0] chirpTicks;
  always_ff @(posedge clk) begin
    if (!rstN)                               chirpTicks <= '0;
    else if (!driveChirpK)                   chirpTicks <= '0;
    else if (usTick && chirpTicks != TMAX)   chirpTicks <= chirpTicks + TW'(1);
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetDetected |=> !resetDetected);

  a_r5_pulse_opens_chirp: assert property (@(posedge clk) disable iff (!rstN)
    resetDetected |-> $rose(driveChirpK));

  a_r2_start_needs_se0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveChirpK) |-> $past(lineState) == LS_SE0);

  a_r5_no_hs_in_chirp: assert property (@(posedge clk) disable iff (!rstN)
    driveChirpK |-> !hsEnable);

  a_r5_chirp_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveChirpK) |-> (chirpTicks >= TW'(CHIRP_TICKS)) && (chirpTicks <= TW'(CHIRP_TICKS + 1)));

  a_r4_revert_on_se0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsEnable) |-> ($past(lineState) == LS_SE0) && !driveChirpK);

  a_r8_hs_after_chirpj: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsEnable) |-> $past(lineState, 3) == LS_CHIRPJ);
endmodule

bind hsnego_top hsnego_checker #(.CHIRP_TICKS(CHIRP_TICKS)) u_chk (
  .clk(clk), .rstN(rstN), .usTick(usTick), .lineState(lineState),
  .driveChirpK(driveChirpK), .hsEnable(hsEnable), .resetDetected(resetDetected)
);

// File: tb/hsnego_top_tb.sv
module hsnego_top_tb;
  localparam int FILT  = 3;
  localparam int SUSP  = 3;
  localparam int FSW   = 10;
  localparam int REV   = 20;
  localparam int SMP   = 5;
  localparam int CHP   = 8;
  localparam int LST   = 40;
  localparam int PAIRS = 3;

  localparam logic [2:0] C_SE0 = 3'd0;
  localparam logic [2:0] C_J   = 3'd1;
  localparam logic [2:0] C_CHJ = 3'd3;
  localparam logic [2:0] C_CHK = 3'd4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic       usTick;
  logic [1:0] tickPh = 2'd0;
  logic [2:0] lineState;
  logic       suspended;
  logic       driveChirpK;
  logic       hsEnable;
  logic       resetDetected;

  int  nChecks = 0;
  int  nFails  = 0;
  int  pulseCnt = 0;
  bit  done = 1'b0;

  // Strobe high for one full period out of four, changing on the falling edge
  always @(negedge clk) tickPh <= tickPh + 2'd1;
  assign usTick = (tickPh == 2'd0);

  always @(negedge clk) if (rstN && resetDetected) pulseCnt++;

  hsnego_top #(
    .FILT_TICKS(FILT), .SUSP_TICKS(SUSP), .FS_WAIT_TICKS(FSW), .REVERT_TICKS(REV),
    .SAMPLE_TICKS(SMP), .CHIRP_TICKS(CHP), .LISTEN_TICKS(LST), .CHIRP_PAIRS(PAIRS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineState(lineState), .suspended(suspended),
    .driveChirpK(driveChirpK), .hsEnable(hsEnable), .resetDetected(resetDetected)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Wait for n strobes, return at the falling edge of the following cycle
  task automatic tickWait(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (usTick !== 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendChirp(input logic isK, input int n);
    lineState = isK ? C_CHK : C_CHJ;
    tickWait(n);
  endtask

  task automatic sendPairsUntilLastJ();
    for (int p = 0; p < PAIRS - 1; p++) begin
      sendChirp(1'b1, 4);
      sendChirp(1'b0, 4);
    end
    sendChirp(1'b1, 4);
  endtask

  initial begin
    rstN = 1'b0;
    lineState = C_J;
    suspended = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 driveChirpK after reset", driveChirpK, 1'b0);
    chk("R1 hsEnable after reset", hsEnable, 1'b0);
    chk("R1 resetDetected after reset", resetDetected, 1'b0);

    // R2: SE0 one strobe short of the window does nothing
    lineState = C_SE0;
    tickWait(FSW - 1);
    lineState = C_J;
    tickWait(3);
    chk("R2 short SE0 no chirp", driveChirpK, 1'b0);
    chkInt("R2 short SE0 no pulse", pulseCnt, 0);

    // R2: full window starts the handshake two cycles after the last strobe
    lineState = C_SE0;
    tickWait(FSW);
    chk("R2 chirp not yet", driveChirpK, 1'b0);
    chk("R2 pulse not yet", resetDetected, 1'b0);
    step();
    chk("R2 pulse due", resetDetected, 1'b1);
    chk("R2 chirp due", driveChirpK, 1'b1);
    step();
    chk("R11 pulse ends", resetDetected, 1'b0);
    chkInt("R11 one pulse", pulseCnt, 1);

    // R5: chirp length
    tickWait(CHP);
    chk("R5 chirp still on", driveChirpK, 1'b1);
    step();
    chk("R5 chirp off", driveChirpK, 1'b0);

    // R6 R7: wrong-kind first, short K, J, then good sequence
    sendChirp(1'b0, 4);
    sendChirp(1'b1, FILT - 1);
    sendChirp(1'b0, 4);
    sendPairsUntilLastJ();
    chk("R6 R7 not complete before last J", hsEnable, 1'b0);
    lineState = C_CHJ;
    tickWait(FILT);
    step();
    chk("R8 hs not yet", hsEnable, 1'b0);
    step();
    chk("R8 hs due", hsEnable, 1'b1);

    // R4: revert at high speed, then line J at sample -> suspend
    lineState = C_J;
    tickWait(2);
    lineState = C_SE0;
    tickWait(REV);
    chk("R4 hs before revert", hsEnable, 1'b1);
    step();
    chk("R4 hs reverted", hsEnable, 1'b0);
    lineState = C_J;
    tickWait(SMP);
    step();
    chk("R4 suspend no chirp", driveChirpK, 1'b0);
    chkInt("R4 suspend no pulse", pulseCnt, 1);

    // R3: suspended full-speed hub starts after the short filter
    suspended = 1'b1;
    lineState = C_SE0;
    tickWait(SUSP);
    chk("R3 chirp not yet", driveChirpK, 1'b0);
    step();
    chk("R3 pulse due", resetDetected, 1'b1);
    chk("R3 chirp due", driveChirpK, 1'b1);
    step();
    suspended = 1'b0;
    tickWait(CHP);
    step();
    chk("R5 chirp off again", driveChirpK, 1'b0);
    sendPairsUntilLastJ();
    lineState = C_CHJ;
    tickWait(FILT);
    step();
    step();
    chk("R8 hs second time", hsEnable, 1'b1);

    // R4: revert and SE0 at sample -> reset handshake
    lineState = C_J;
    tickWait(2);
    lineState = C_SE0;
    tickWait(REV);
    step();
    chk("R4 hs reverted again", hsEnable, 1'b0);
    tickWait(SMP);
    chk("R4 chirp not yet at sample", driveChirpK, 1'b0);
    step();
    chk("R4 reset pulse", resetDetected, 1'b1);
    chk("R4 chirp after sample", driveChirpK, 1'b1);
    step();

    // R9 R10: listen deadline expires, SE0 continues, late chirps
    tickWait(CHP);
    step();
    tickWait(LST);
    step();
    tickWait(FSW + 2);
    chk("R10 no new chirp in SE0", driveChirpK, 1'b0);
    chkInt("R10 no new pulse", pulseCnt, 3);
    for (int p = 0; p < PAIRS; p++) begin
      sendChirp(1'b1, 4);
      sendChirp(1'b0, 4);
    end
    step();
    step();
    chk("R9 late chirps ignored", hsEnable, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule